// File: doc/BRIEF.md
# I2C Bit-Rate Generator

This block turns the system clock into the timing ticks an I2C master needs to drive SCL. Two small registers, each written by a one-cycle strobe with data, set the rate: a 4-bit mode register and an 8-bit divisor. The clock first passes through a power-of-two pre-divider, chosen by a two-bit code. It then passes through a second counter whose length is the divisor plus a fixed offset. The offset is 3, plus 2 more when the filter bit is set.

While enabled, the block emits a one-cycle `tick` at each half of the SCL period and toggles a free-running `scl_ref` level on every tick. One full SCL cycle is therefore two ticks, so the bit rate is clk / (pre × 2 × (divisor + 3 + 2 × filter)). New divisor or mode settings are held back until the current half-period ends, so an interval already under way is never stretched or cut short. While disabled, both counters sit at zero and both outputs are low.

Top module: `i2c_rate_gen`

## Requirements
- R1: Mode bits 2:1 hold the pre-divider code. Codes 0, 1, 2 and 3 divide the clock by 32, 16, 8 and 4.
- R2: Mode bit 3 is the filter bit. The second-stage length is N = divisor + 3 + 2 × filter, where the divisor is the 8-bit value last written through `div_we`.
- R3: While running, consecutive `tick` pulses are exactly pre × N clock cycles apart, and each pulse lasts one cycle.
- R4: `scl_ref` toggles in the cycle in which `tick` is high and holds its level at all other times while running. It starts low after each enable.
- R5: Mode bit 0 is the enable. From the second cycle after a write that clears it, `tick` and `scl_ref` stay low and divisor writes produce no ticks.
- R6: After a mode write that sets the enable, the first `tick` is seen pre × N + 1 cycles after the write edge, using the values programmed at that write.
- R7: A divisor or mode write while running leaves the half-period in progress unchanged. The new values apply from the next half-period on.
- R8: The extreme divisors 0 and 255 give N = 3 or 5 and N = 258 or 260 for each pre-divider code.
- R9: Under reset and afterwards, with no register written, `tick` and `scl_ref` are low. Both registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 4 | Mode data: bit 0 enable, bits 2:1 pre-divider code, bit 3 filter |
| div_we | input | 1 | Write strobe for the divisor register |
| div_wdata | input | DIV_W (8) | Divisor value |
| tick | output | 1 | One-cycle pulse at each SCL half-period |
| scl_ref | output | 1 | SCL reference level, toggled by each tick |

## Verification
An enabling write takes effect at its clock edge. One cycle later the programmed values are copied into the active set, and counting starts on the next edge. The tick register therefore rises pre × N + 1 edges after the write, and every later tick follows pre × N edges after the one before. The bench notes the cycle number right after each enabling edge and pushes the expected gaps into a queue. It samples `tick` and `scl_ref` on the falling edge, away from any update, and compares each measured gap with the head of the queue. Mid-run writes are timed to fall inside a known half-period, so the queue holds the old spacing first and the new spacing next. Disable checks start two edges after the disabling write, to cover its register stages.

// File: rtl/i2c_rate_pkg.sv
// Package: shared field layout and helpers for the I2C bit-rate generator.
// Assumes the mode register is 4 bits with the field positions below.
package i2c_rate_pkg;

    localparam int MODE_W    = 4;
    localparam int SEL_W     = 2;
    localparam int FIXED_OFS = 3;
    localparam int FILT_OFS  = 2;

    // Mode register layout, MSB first: filter(3), select(2:1), enable(0)
    typedef struct packed {
        logic             filt;
        logic [SEL_W-1:0] sel;
        logic             en;
    } rate_mode_t;

    // Pre-divider ratio for a select code: 2^(log_max - sel)
    function automatic int pre_ratio(input int log_max, input logic [SEL_W-1:0] sel);
        return 1 << (log_max - int'(sel));
    endfunction

endpackage

// File: rtl/i2c_rate_regs.sv
// Module: i2c_rate_regs
// Holds the programmed mode and divisor registers and the active copy the
// counters use. The active copy reloads while the generator is stopped and
// at every terminal count, so a change never lands mid-interval.
// Assumes writes are single-cycle strobes sampled on the clock edge.
module i2c_rate_regs
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             term,
    output logic             en,
    output logic             run,
    output logic             hold,
    output logic [SEL_W-1:0] act_sel,
    output logic             act_filt,
    output logic [DIV_W-1:0] act_div
);

    rate_mode_t       mode_q;
    logic [DIV_W-1:0] div_q;
    logic             run_q;
    logic [SEL_W-1:0] sel_a_q;
    logic             filt_a_q;
    logic [DIV_W-1:0] div_a_q;

    // Programmed registers: capture write data on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
        end else begin
            if (mode_we) mode_q <= rate_mode_t'(mode_wdata);
            if (div_we)  div_q  <= div_wdata;
        end
    end

    // Run flag: enable delayed one cycle so the active set loads first
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= mode_q.en;
    end

    // Active set: follow programmed values while stopped or at terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_a_q  <= '0;
            filt_a_q <= 1'b0;
            div_a_q  <= '0;
        end else if (!run_q || term) begin
            sel_a_q  <= mode_q.sel;
            filt_a_q <= mode_q.filt;
            div_a_q  <= div_q;
        end
    end

    // Outputs to the counters
    always_comb begin
        en       = mode_q.en;
        run      = run_q;
        hold     = !(mode_q.en && run_q);
        act_sel  = sel_a_q;
        act_filt = filt_a_q;
        act_div  = div_a_q;
    end

endmodule

// File: rtl/i2c_rate_prescale.sv
// Module: i2c_rate_prescale
// First-stage power-of-two divider. Emits a one-cycle strobe every
// 2^(LOG_MAX - sel) cycles. Assumes LOG_MAX is at least 2^SEL_W - 1.
module i2c_rate_prescale
    import i2c_rate_pkg::*;
#(
    parameter int LOG_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [SEL_W-1:0] sel,
    output logic             strobe
);

    localparam int CNT_W = LOG_MAX;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Terminal value for the selected ratio
    always_comb begin
        last   = CNT_W'(pre_ratio(LOG_MAX, sel) - 1);
        strobe = !hold && (cnt_q == last);
    end

    // Counter: cleared while held, wraps at the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n || hold)   cnt_q <= '0;
        else if (cnt_q == last) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2c_rate_halfdiv.sv
// Module: i2c_rate_halfdiv
// Second-stage divider. Counts prescaler strobes up to
// div + FIXED_OFS + FILT_OFS*filt, then registers a tick and toggles the
// SCL reference. Assumes the strobe is never high two cycles in a row.
module i2c_rate_halfdiv
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             strobe,
    input  logic [DIV_W-1:0] div,
    input  logic             filt,
    output logic             term,
    output logic             tick,
    output logic             scl_ref
);

    localparam int N_W = DIV_W + 2;

    logic [N_W-1:0] cnt_q;
    logic [N_W-1:0] last;
    logic           tick_q;
    logic           scl_q;

    // Terminal index is length minus one
    always_comb begin
        last = N_W'(div) + N_W'(FIXED_OFS - 1) + (filt ? N_W'(FILT_OFS) : '0);
        term = strobe && (cnt_q == last);
    end

    // Strobe counter: advances on strobe, wraps at terminal, cleared when held
    always_ff @(posedge clk) begin
        if (!rst_n || hold) cnt_q <= '0;
        else if (term)      cnt_q <= '0;
        else if (strobe)    cnt_q <= cnt_q + 1'b1;
    end

    // Output stage: one-cycle tick and toggling reference level
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            tick_q <= 1'b0;
            scl_q  <= 1'b0;
        end else begin
            tick_q <= term;
            if (term) scl_q <= ~scl_q;
        end
    end

    assign tick    = tick_q;
    assign scl_ref = scl_q;

endmodule

// File: rtl/i2c_rate_gen.sv
// Module: i2c_rate_gen (top)
// I2C bit-rate generator: register file, power-of-two prescaler and
// second-stage divider in cascade. Assumes synchronous active-low reset and
// single-cycle write strobes.
module i2c_rate_gen
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LOG = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic              tick,
    output logic              scl_ref
);

    logic             en;
    logic             run;
    logic             hold;
    logic             term;
    logic             strobe;
    logic [SEL_W-1:0] act_sel;
    logic             act_filt;
    logic [DIV_W-1:0] act_div;

    i2c_rate_regs #(.DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .div_we     (div_we),
        .div_wdata  (div_wdata),
        .term       (term),
        .en         (en),
        .run        (run),
        .hold       (hold),
        .act_sel    (act_sel),
        .act_filt   (act_filt),
        .act_div    (act_div)
    );

    i2c_rate_prescale #(.LOG_MAX(PRE_LOG)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold   (hold),
        .sel    (act_sel),
        .strobe (strobe)
    );

    i2c_rate_halfdiv #(.DIV_W(DIV_W)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (hold),
        .strobe  (strobe),
        .div     (act_div),
        .filt    (act_filt),
        .term    (term),
        .tick    (tick),
        .scl_ref (scl_ref)
    );

endmodule

// File: rtl/i2c_rate_chk.sv
// Module: i2c_rate_chk
// Temporal checks for i2c_rate_gen, attached with bind below.
module i2c_rate_chk
    import i2c_rate_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             run,
    input logic             term,
    input logic             tick,
    input logic             scl_ref,
    input logic [SEL_W-1:0] act_sel,
    input logic             act_filt,
    input logic [DIV_W-1:0] act_div
);

    // R5: disabled generator is quiet on the next edge
    p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!tick && !scl_ref));

    // R3: tick is a single-cycle pulse
    p_tick_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4: every tick flips the reference level
    p_scl_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (scl_ref != $past(scl_ref)));

    // R4: without a tick the level holds while running
    p_scl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run && !tick) |-> $stable(scl_ref));

    // R7: active settings frozen inside a running half-period
    p_active_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !term) |=> ($stable(act_sel) && $stable(act_filt) && $stable(act_div)));

endmodule

bind i2c_rate_gen i2c_rate_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .run      (run),
    .term     (term),
    .tick     (tick),
    .scl_ref  (scl_ref),
    .act_sel  (act_sel),
    .act_filt (act_filt),
    .act_div  (act_div)
);

// File: tb/i2c_rate_gen_tb_top.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue expected tick gaps, a falling-edge
// monitor measures actual gaps and compares.
module i2c_rate_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [3:0] mode_wdata = '0;
    logic       div_we = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       tick;
    logic       scl_ref;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int last_t = 0;
    logic scl_exp = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    i2c_rate_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .div_we     (div_we),
        .div_wdata  (div_wdata),
        .tick       (tick),
        .scl_ref    (scl_ref)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        if (cyc > 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL R3 watchdog actual=%0d expected<=%0d", cyc, 190000);
            finish_run();
        end
    end

    // Monitor: measure each tick gap and the reference level
    always @(negedge clk) begin
        if (rst_n && tick) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected tick", 1, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, cyc - last_t, e);
                last_t  = cyc;
                scl_exp = ~scl_exp;
                check("R4 scl level", int'(scl_ref), int'(scl_exp));
            end
        end
    end

    task automatic write_mode(input logic en, input logic [1:0] sel, input logic f);
        @(posedge clk); #1;
        mode_we = 1'b1; mode_wdata = {f, sel, en};
        @(posedge clk); #1;
        mode_we = 1'b0;
    endtask

    task automatic write_div(input logic [7:0] v);
        @(posedge clk); #1;
        div_we = 1'b1; div_wdata = v;
        @(posedge clk); #1;
        div_we = 1'b0;
    endtask

    task automatic expect_gap(input int g, input string tag);
        exp_q.push_back(g);
        tag_q.push_back(tag);
    endtask

    // Enable with the current programming; first gap is from the write edge
    task automatic start_gen(input logic [1:0] sel, input logic f);
        scl_exp = 1'b0;
        write_mode(1'b1, sel, f);
        last_t = cyc;
    endtask

    // Disable, then prove silence at the ports
    task automatic stop_and_check(input string tag);
        int viol;
        viol = 0;
        write_mode(1'b0, 2'd3, 1'b0);
        @(posedge clk); #1;
        div_we = 1'b1; div_wdata = 8'd1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tick || scl_ref) viol++;
            if (i == 1) div_we = 1'b0;
        end
        check(tag, viol, 0);
    endtask

    task automatic run_cfg(input logic [1:0] sel, input logic f, input logic [7:0] d);
        int p;
        int n;
        string tg;
        p  = 32 >> sel;
        n  = int'(d) + 3 + 2 * int'(f);
        tg = $sformatf("R3 R1 R2 R8 sel=%0d filt=%0d div=%0d", sel, f, d);
        write_mode(1'b0, sel, f);
        write_div(d);
        expect_gap(p * n + 1, {"R6 first ", tg});
        expect_gap(p * n, tg);
        start_gen(sel, f);
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
        mode_we = 1'b1; mode_wdata = {f, sel, 1'b0};
        @(posedge clk); #1;
        mode_we = 1'b0;
    endtask

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 tick in reset", int'(tick), 0);
        check("R9 scl in reset", int'(scl_ref), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        begin
            int viol;
            viol = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (tick || scl_ref) viol++;
            end
            check("R9 idle after reset", viol, 0);
        end

        // R1 R2 R8: every code, both filter settings, extreme divisors
        for (int s = 0; s < 4; s++)
            for (int f = 0; f < 2; f++) begin
                run_cfg(2'(s), 1'(f), 8'd0);
                run_cfg(2'(s), 1'(f), 8'd255);
            end
        repeat (3) @(posedge clk);

        // R7: changes mid-interval apply at the next terminal count
        write_mode(1'b0, 2'd3, 1'b0);
        write_div(8'd2);
        expect_gap(21, "R6 first tick pre=4 N=5");
        expect_gap(20, "R7 interval before divisor write");
        expect_gap(40, "R7 new divisor applied");
        expect_gap(80, "R7 new select applied");
        start_gen(2'd3, 1'b0);
        repeat (24) @(posedge clk);
        #1;
        div_we = 1'b1; div_wdata = 8'd7;
        @(posedge clk); #1;
        div_we = 1'b0;
        wait (exp_q.size() == 2);
        write_mode(1'b1, 2'd2, 1'b0);
        wait (exp_q.size() == 0);

        // R5: disable silences outputs, divisor writes ignored
        stop_and_check("R5 quiet while disabled");

        // R5 R6: re-enable restarts from zeroed counters
        write_div(8'd4);
        expect_gap(8 * 9 + 1, "R6 restart latency pre=8 N=9");
        expect_gap(8 * 9, "R3 restart spacing");
        start_gen(2'd2, 1'b1);
        wait (exp_q.size() == 0);
        stop_and_check("R5 quiet after second stop");

        finish_run();
    end

endmodule